// File: doc/BRIEF.md
# Display Control-Byte Stream Parser

This block sits behind a two-wire serial slave front end and makes sense of the bytes of one addressed write transfer to a display controller. Each transfer starts with a control byte. Bit 7 of the control byte is a continuation flag and bit 6 is a routing select. The parser sorts the bytes that follow the control byte. It sends a data byte to the setup-command decoder when the routing select is 0. It sends the data byte to display memory at an auto-advancing pointer when the routing select is 1.

While the continuation flag is 1, control bytes and data bytes alternate one for one. A control byte with the flag cleared is the last control byte of the transfer. Every byte after it, until the transfer ends, is a data byte routed by that final select. The routing select also sets the read mode, and the read mode survives transfer boundaries. A later read therefore returns either the live status byte (select 0) or a fixed filler byte (select 1). The memory pointer is loaded from the command side and wraps to zero after a parameterised maximum.

Top module: `ctrl_stream_parser`

## Requirements
- R1: After reset the parser expects a control byte, the read mode is status (rd_sel = 0), no strobe is active and the memory pointer is 0.
- R2: A control byte with bit 7 = 1 is followed by exactly one data byte, and the byte after that is treated as a control byte again.
- R3: After a control byte with bit 7 = 0, every byte is a data byte until xfer_stop or xfer_start is pulsed.
- R4: A data byte under select 1 raises ram_we for one cycle, in the cycle after byte_vld. In that cycle ram_wdata carries the byte and ram_addr carries the pointer value, and the pointer then advances by one.
- R5: A data byte under select 0 raises cmd_vld for one cycle, in the cycle after byte_vld, with the byte on cmd_byte.
- R6: A control byte produces no strobe, and its bits 5 to 0 have no effect on routing or sequencing.
- R7: A pulse on xfer_start (start or repeated start) or on xfer_stop returns the parser to expecting a control byte.
- R8: The pointer wraps from PTR_MAX to 0 when it advances.
- R9: A ptr_load pulse sets the pointer to ptr_val. If a memory write happens in the same cycle, the write uses the old pointer and the loaded value wins over the advance.
- R10: rd_sel takes the value of bit 6 of each control byte and keeps it across xfer_start and xfer_stop. rd_byte equals status_in when rd_sel = 0 and equals FILL_BYTE when rd_sel = 1.
- R11: cmd_vld and ram_we are never high together, and neither is high unless byte_vld was high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Start or repeated start seen, one-cycle pulse |
| xfer_stop | input | 1 | Stop seen, one-cycle pulse |
| byte_vld | input | 1 | Received write byte valid, one-cycle pulse |
| byte_in | input | 8 | Received write byte |
| ptr_load | input | 1 | Load the memory pointer |
| ptr_val | input | PW | Pointer load value, at most PTR_MAX |
| status_in | input | 8 | Live status byte for reads |
| cmd_vld | output | 1 | Setup-command byte strobe |
| cmd_byte | output | 8 | Setup-command byte |
| ram_we | output | 1 | Display memory write strobe |
| ram_addr | output | PW | Display memory write address |
| ram_wdata | output | 8 | Display memory write data |
| rd_sel | output | 1 | Read mode: 0 status, 1 filler |
| rd_byte | output | 8 | Byte to send during a read |

## Verification
The assertions assume that the front end never raises byte_vld in the same cycle as xfer_start or xfer_stop. They also assume that ptr_val never exceeds PTR_MAX when it is loaded. The bench drives only byte pulses separated by idle cycles, and it drives boundary pulses in cycles of their own. The random pointer loads are drawn from 0 to PTR_MAX, with extra weight on the top two values so that the wrap occurs often.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [1:0] {
    PH_CTRL = 2'd0,  // next byte is a control byte
    PH_ONE  = 2'd1,  // one data byte, then control again
    PH_RUN  = 2'd2   // data bytes until the transfer ends
  } phase_t;

  localparam int CONT_BIT = 7;
  localparam int SEL_BIT  = 6;
endpackage

// File: rtl/cps_phase_fsm.sv
module cps_phase_fsm
  import cps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xfer_start,
  input  logic       xfer_stop,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  output phase_t     phase,
  output logic       sel,
  output logic       data_fire
);
  phase_t phase_d;
  logic   sel_d;
  logic   boundary;

  assign boundary  = xfer_start | xfer_stop;
  assign data_fire = byte_vld & ~boundary & (phase != PH_CTRL);

  always_comb begin
    phase_d = phase;
    sel_d   = sel;
    if (boundary) begin
      phase_d = PH_CTRL;
    end else if (byte_vld) begin
      unique case (phase)
        PH_CTRL: begin
          sel_d   = byte_in[SEL_BIT];
          phase_d = byte_in[CONT_BIT] ? PH_ONE : PH_RUN;
        end
        PH_ONE:  phase_d = PH_CTRL;
        PH_RUN:  phase_d = PH_RUN;
        default: phase_d = PH_CTRL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_CTRL;
      sel   <= 1'b0;
    end else begin
      phase <= phase_d;
      sel   <= sel_d;
    end
  end
endmodule

// File: rtl/cps_data_ptr.sv
module cps_data_ptr #(
  parameter int PTR_MAX = 815,
  parameter int PW      = $clog2(PTR_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  input  logic          adv,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] TOP = PW'(PTR_MAX);

  logic [PW-1:0] ptr_d;
  logic          ptr_en;

  assign ptr_en = load | adv;

  always_comb begin
    if (load)            ptr_d = load_val;
    else if (ptr >= TOP) ptr_d = '0;
    else                 ptr_d = ptr + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (ptr_en) ptr <= ptr_d;
  end
endmodule

// File: rtl/ctrl_stream_parser.sv
module ctrl_stream_parser
  import cps_pkg::*;
#(
  parameter int         PTR_MAX   = 815,
  parameter int         PW        = $clog2(PTR_MAX + 1),
  parameter logic [7:0] FILL_BYTE = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfer_start,
  input  logic          xfer_stop,
  input  logic          byte_vld,
  input  logic [7:0]    byte_in,
  input  logic          ptr_load,
  input  logic [PW-1:0] ptr_val,
  input  logic [7:0]    status_in,
  output logic          cmd_vld,
  output logic [7:0]    cmd_byte,
  output logic          ram_we,
  output logic [PW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  output logic          rd_sel,
  output logic [7:0]    rd_byte
);
  phase_t        phase;
  logic          data_fire;
  logic          ram_fire;
  logic          cmd_fire;
  logic [PW-1:0] ptr_q;

  cps_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .xfer_stop  (xfer_stop),
    .byte_vld   (byte_vld),
    .byte_in    (byte_in),
    .phase      (phase),
    .sel        (rd_sel),
    .data_fire  (data_fire)
  );

  assign ram_fire = data_fire & rd_sel;
  assign cmd_fire = data_fire & ~rd_sel;

  cps_data_ptr #(.PTR_MAX(PTR_MAX), .PW(PW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ptr_load),
    .load_val (ptr_val),
    .adv      (ram_fire),
    .ptr      (ptr_q)
  );

  // Output stage: strobes every cycle, payload on enable
  logic          cmd_vld_d, ram_we_d;

  always_comb begin
    cmd_vld_d = cmd_fire;
    ram_we_d  = ram_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_vld <= 1'b0;
      ram_we  <= 1'b0;
    end else begin
      cmd_vld <= cmd_vld_d;
      ram_we  <= ram_we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmd_byte <= '0;
    else if (cmd_fire) cmd_byte <= byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_wdata <= '0;
      ram_addr  <= '0;
    end else if (ram_fire) begin
      ram_wdata <= byte_in;
      ram_addr  <= ptr_q;
    end
  end

  assign rd_byte = rd_sel ? FILL_BYTE : status_in;
endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
  parameter int PTR_MAX = 815,
  parameter int PW      = $clog2(PTR_MAX + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          xfer_start,
  input logic          xfer_stop,
  input logic          byte_vld,
  input logic [7:0]    byte_in,
  input logic          ptr_load,
  input logic          cmd_vld,
  input logic [7:0]    cmd_byte,
  input logic          ram_we,
  input logic [7:0]    ram_wdata,
  input logic          rd_sel,
  input logic [1:0]    phase,
  input logic          ram_fire,
  input logic [PW-1:0] ptr_q
);
  // R11
  excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_vld, ram_we}));

  // R11
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld || ram_we) |-> $past(byte_vld));

  // R5
  cmd_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> cmd_byte == $past(byte_in));

  // R4
  ram_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_wdata == $past(byte_in));

  // R6
  ctrl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && phase == 2'd0 && !xfer_start && !xfer_stop) |=> (!cmd_vld && !ram_we));

  // R10
  sel_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && phase == 2'd0 && !xfer_start && !xfer_stop) |=> rd_sel == $past(byte_in[6]));

  // R7
  boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start || xfer_stop) |=> phase == 2'd0);

  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_fire && !ptr_load && ptr_q >= PW'(PTR_MAX)) |=> ptr_q == '0);
endmodule

bind ctrl_stream_parser cps_checker #(.PTR_MAX(PTR_MAX), .PW(PW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_start (xfer_start),
  .xfer_stop  (xfer_stop),
  .byte_vld   (byte_vld),
  .byte_in    (byte_in),
  .ptr_load   (ptr_load),
  .cmd_vld    (cmd_vld),
  .cmd_byte   (cmd_byte),
  .ram_we     (ram_we),
  .ram_wdata  (ram_wdata),
  .rd_sel     (rd_sel),
  .phase      (phase),
  .ram_fire   (ram_fire),
  .ptr_q      (ptr_q)
);

// File: tb/ctrl_stream_parser_test.sv
module ctrl_stream_parser_test;
  localparam int         CLK_PERIOD = 10;
  localparam int         PMAX       = 815;
  localparam int         PW         = $clog2(PMAX + 1);
  localparam logic [7:0] FILL       = 8'hFF;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          xfer_start, xfer_stop, byte_vld, ptr_load;
  logic [7:0]    byte_in, status_in;
  logic [PW-1:0] ptr_val;
  logic          cmd_vld, ram_we, rd_sel;
  logic [7:0]    cmd_byte, ram_wdata, rd_byte;
  logic [PW-1:0] ram_addr;

  ctrl_stream_parser uut (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_stop(xfer_stop),
    .byte_vld(byte_vld), .byte_in(byte_in), .ptr_load(ptr_load), .ptr_val(ptr_val),
    .status_in(status_in), .cmd_vld(cmd_vld), .cmd_byte(cmd_byte), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .rd_sel(rd_sel), .rd_byte(rd_byte)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int m_phase;   // 0 control, 1 single data, 2 data run
  logic m_sel;
  int m_ptr;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int next_ptr(input int p);
    return (p >= PMAX) ? 0 : p + 1;
  endfunction

  task automatic check_read();
    status_in = 8'($urandom);
    #1;
    chk(rd_sel == m_sel, "R10 rd_sel", int'(rd_sel), int'(m_sel));
    chk(rd_byte == (m_sel ? FILL : status_in), "R10 rd_byte", rd_byte, m_sel ? FILL : status_in);
  endtask

  // Send one byte, optionally with a pointer load in the same cycle.
  task automatic send(input logic [7:0] v, input logic ld, input int lv);
    logic e_cmd, e_we;
    int   e_addr;
    e_cmd = 0; e_we = 0; e_addr = 0;
    if (m_phase == 0) begin
      m_sel   = v[6];
      m_phase = v[7] ? 1 : 2;
      if (ld) m_ptr = lv;
    end else begin
      if (m_sel) begin
        e_we = 1; e_addr = m_ptr;
        m_ptr = ld ? lv : next_ptr(m_ptr);
      end else begin
        e_cmd = 1;
        if (ld) m_ptr = lv;
      end
      if (m_phase == 1) m_phase = 0;
    end
    byte_vld = 1; byte_in = v; ptr_load = ld; ptr_val = PW'(lv);
    @(posedge clk); @(negedge clk);
    byte_vld = 0; ptr_load = 0;
    chk(cmd_vld == e_cmd, "R5/R6 cmd_vld", int'(cmd_vld), int'(e_cmd));
    chk(ram_we == e_we, "R4/R6 ram_we", int'(ram_we), int'(e_we));
    if (e_cmd) chk(cmd_byte == v, "R5 cmd_byte", cmd_byte, v);
    if (e_we) begin
      chk(ram_wdata == v, "R4 ram_wdata", ram_wdata, v);
      chk(int'(ram_addr) == e_addr, "R4/R8/R9 ram_addr", int'(ram_addr), e_addr);
    end
    check_read();
    @(negedge clk);
    chk(!cmd_vld && !ram_we, "R11 idle", int'({cmd_vld, ram_we}), 0);
  endtask

  task automatic boundary(input logic is_stop);
    xfer_start = !is_stop; xfer_stop = is_stop;
    @(posedge clk); @(negedge clk);
    xfer_start = 0; xfer_stop = 0;
    m_phase = 0;
    chk(!cmd_vld && !ram_we, "R7 boundary quiet", int'({cmd_vld, ram_we}), 0);
    check_read();
  endtask

  task automatic load(input int lv);
    ptr_load = 1; ptr_val = PW'(lv);
    @(posedge clk); @(negedge clk);
    ptr_load = 0;
    m_ptr = lv;
  endtask

  logic done = 0;
  int   cyc  = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0; xfer_start = 0; xfer_stop = 0; byte_vld = 0; ptr_load = 0;
    byte_in = 0; ptr_val = 0; status_in = 8'h3C;
    m_phase = 0; m_sel = 0; m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!cmd_vld && !ram_we, "R1 no strobe", int'({cmd_vld, ram_we}), 0);
    chk(rd_sel == 0, "R1 rd_sel", int'(rd_sel), 0);
    check_read();

    // R1/R3: pointer starts at 0, run of memory data
    boundary(0);
    send(8'h40, 0, 0);
    send(8'h11, 0, 0);
    send(8'h22, 0, 0);
    send(8'h33, 0, 0);
    // R7: stop then control expected; R6: low bits ignored, Co=1 DC=0
    boundary(1);
    send(8'hBF, 0, 0);
    send(8'hA5, 0, 0);   // R2 single command byte
    send(8'hC0, 0, 0);   // R2 control again, Co=1 DC=1
    send(8'h5A, 0, 0);   // memory
    send(8'h3F, 0, 0);   // control Co=0 DC=0, R6 low bits ignored
    send(8'hC1, 0, 0);   // R3 command even with top bits set
    send(8'h80, 0, 0);   // R3 still data
    // R8 wrap
    boundary(0);
    send(8'h40, 0, 0);
    load(PMAX - 1);
    send(8'h01, 0, 0);
    send(8'h02, 0, 0);
    send(8'h03, 0, 0);
    // R9 load during write: write uses old pointer, load wins
    send(8'h04, 1, 100);
    send(8'h05, 0, 0);
    // R10: select persists across start and stop
    boundary(1);
    boundary(0);

    // Random transfers
    for (int t = 0; t < 400; t++) begin
      boundary($urandom_range(0, 1) == 1);
      for (int n = 0; n < int'($urandom_range(0, 12)); n++) begin
        logic ld;
        int   lv;
        ld = ($urandom_range(0, 9) == 0);
        lv = ($urandom_range(0, 1) == 1) ? int'($urandom_range(PMAX - 1, PMAX))
                                         : int'($urandom_range(0, PMAX));
        send(8'($urandom), ld, lv);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule